// File: doc/BRIEF.md
# Counter-Seeded Double Syndrome Generator

This block turns a 144-bit hashed message and an attempt counter into a candidate double syndrome. The syndrome is 18 coefficients of 16 bits each, which a later decoding step consumes. The block keeps its own attempt counter, which can be cleared or stepped by one. A start request copies that counter into a 25-stage linear feedback shift register, and the seed is forced nonzero. The block then walks the 144 rows of a stored 144 x 288 matrix. For each row it XORs one message bit with one pseudo-random bit. When the result is 1, the whole 288-bit row is added (XOR) into the accumulator.

The matrix is held outside the block, for example as 18 banks of 16 bits sharing one row address. The block drives a row address and a read enable. It expects the full 288-bit row on its data input one cycle later. The gating bit is delayed by the same cycle so that it meets its own row. A single-cycle done pulse marks the end of the run. The syndrome stays on its output until the next run begins.

The controller is a four-state machine:
- IDLE: waits for start.
- SEED: loads the shift register and clears the accumulator.
- SCAN: issues the 144 row reads.
- DRAIN: adds the last row and raises done.

Its transitions are named:
- T_GO: IDLE to SEED, when start is high.
- T_ARM: SEED to SCAN, unconditional.
- T_LAST: SCAN to DRAIN, after row 143 is issued.
- T_FIN: DRAIN to IDLE, unconditional.

Top module: `syndrome_builder`

## Requirements
- R1: The attempt counter output `attempt` resets to 0. A cycle with `cnt_clr` high sets it to 0. A cycle with `cnt_inc` high and `cnt_clr` low adds 1. When both are high, clear wins.
- R2: On T_GO, the seed loaded in the SEED cycle is `attempt | 1`, using the counter value held at that cycle. Later counter changes during the run do not affect the result. The accumulator is cleared in the SEED cycle.
- R3: The shift register state s[24:0] gives bit s[0] as the pseudo-random bit for the current row. After each row it moves to {s[0]^s[3], s[24:1]}.
- R4: For row j (j = 0..143) the gating bit is msg[j] XOR the pseudo-random bit for that row. Row j is XORed into the accumulator exactly when the gating bit is 1. The syndrome is therefore the XOR of all gated rows, and it is zero when no row is gated.
- R5: During a run, `rd_en` is high for exactly 144 consecutive cycles, with `rd_addr` stepping 0, 1, …, 143. `rd_data` is taken as the row addressed one cycle earlier.
- R6: Coefficient k (k = 0..17) of the syndrome sits at `syn[16k+15:16k]`, and it is bit-aligned with `rd_data[16k+15:16k]`. Between runs `syn` holds its value.
- R7: `done` is high for exactly one cycle. If `start` is high at posedge number E0, then `done` is high in the cycle after posedge E0+146. At that moment `syn` holds the final result.
- R8: A `start` pulse while a run is in progress (SEED, SCAN or DRAIN) is ignored. It does not restart the run, and it does not produce an extra done.
- R9: Attempt counter values 0 and 1 give the same syndrome for the same message, because the seed is forced nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_clr | input | 1 | Clear the attempt counter |
| cnt_inc | input | 1 | Add one to the attempt counter |
| start | input | 1 | Begin a syndrome run (taken only in IDLE) |
| msg | input | 144 | Hashed message; bit j gates row j |
| rd_en | output | 1 | Matrix row read request |
| rd_addr | output | 8 | Matrix row index |
| rd_data | input | 288 | Matrix row, one cycle after the request |
| syn | output | 288 | Accumulated syndrome, 18 x 16-bit coefficients |
| done | output | 1 | One-cycle end-of-run pulse |
| attempt | output | 25 | Attempt counter value |

## Verification
The assertions assume three things about the inputs:
- `msg` is held steady from start until done, because the bits are read live during SCAN.
- The matrix memory returns the addressed row exactly one cycle after `rd_en`.
- The counter is not changed in the cycle between start and SEED.

The bench meets all three:
- It changes `msg` only while idle.
- Its memory model registers a computed row on each read.
- It pulses counter controls either before start or well inside SCAN.

The mid-run counter pulses and stray start pulses come late enough to probe R2 and R8 without breaking these assumptions.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int MSG_BITS_D = 144;
    localparam int PRNG_W_D   = 25;
    localparam int COEF_W_D   = 16;
    localparam int N_COEF_D   = 18;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEED  = 2'd1,
        ST_SCAN  = 2'd2,
        ST_DRAIN = 2'd3
    } sb_state_e;
endpackage

// File: rtl/sb_attempt_ctr.sv
module sb_attempt_ctr #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end

    // R1: clear has priority and takes effect on the next edge
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0));
    // R1: a lone increment steps by exactly one
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (value == $past(value) + 1'b1));
endmodule

// File: rtl/sb_lfsr.sv
module sb_lfsr #(
    parameter int W       = 25,
    parameter int TAP     = 3,
    parameter int SEED_OR = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic         out_bit
);
    localparam logic [W-1:0] FORCE = W'(SEED_OR);

    logic [W-1:0] state;
    logic         fb;

    always_comb begin
        fb      = state[0] ^ state[TAP];
        out_bit = state[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FORCE;
        end else if (load) begin
            state <= seed | FORCE;
        end else if (step) begin
            state <= {fb, state[W-1:1]};
        end
    end

    // R2: a freshly loaded seed is never all zeros
    a_r2_seed_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state != '0));
    // R3: a nonzero register stays nonzero while it steps
    a_r3_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state != '0) |=> (state != '0));
endmodule

// File: rtl/sb_accum.sv
module sb_accum #(
    parameter int N_COEF = 18,
    parameter int COEF_W = 16,
    localparam int ROW_W = N_COEF * COEF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add,
    input  logic [ROW_W-1:0] row,
    output logic [ROW_W-1:0] syn
);
    for (genvar k = 0; k < N_COEF; k++) begin : g_lane
        logic [COEF_W-1:0] coef;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                coef <= '0;
            end else if (clear) begin
                coef <= '0;
            end else if (add) begin
                coef <= coef ^ row[k*COEF_W +: COEF_W];
            end
        end

        assign syn[k*COEF_W +: COEF_W] = coef;
    end

    // R6: with no clear and no add the syndrome holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !add) |=> $stable(syn));
    // R2: clearing leaves every coefficient zero
    a_r2_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (syn == '0));
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int STEPS = 144,
    localparam int IDX_W = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             seed_load,
    output logic             acc_clear,
    output logic             scan,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

    sb_state_e state, state_nx;
    logic      at_last;

    assign at_last = (idx == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SEED;     // T_GO
            ST_SEED:  state_nx = ST_SCAN;                // T_ARM
            ST_SCAN:  if (at_last) state_nx = ST_DRAIN;  // T_LAST
            ST_DRAIN: state_nx = ST_IDLE;                // T_FIN
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        seed_load = 1'b0;
        acc_clear = 1'b0;
        scan      = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_SEED:  begin seed_load = 1'b1; acc_clear = 1'b1; end
            ST_SCAN:  scan = 1'b1;
            ST_DRAIN: ;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= (state == ST_DRAIN);
            if (state == ST_SEED) begin
                idx <= '0;
            end else if (scan && !at_last) begin
                idx <= idx + 1'b1;
            end
        end
    end

    // R5: consecutive reads walk the rows upward by one
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && $past(scan)) |-> (idx == $past(idx) + 1'b1));
    // R5: a read window opens at row zero
    a_r5_first_row: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan) |-> (idx == '0));
    // R5: no address beyond the last row
    a_r5_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        scan |-> (idx <= LAST_IDX));
    // R7: done lasts a single cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: a start during scanning does not reseed
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && start) |=> !seed_load);
endmodule

// File: rtl/syndrome_builder.sv
module syndrome_builder
    import sb_pkg::*;
#(
    parameter int MSG_BITS = MSG_BITS_D,
    parameter int PRNG_W   = PRNG_W_D,
    parameter int PRNG_TAP = 3,
    parameter int COEF_W   = COEF_W_D,
    parameter int N_COEF   = N_COEF_D,
    localparam int ROW_W   = N_COEF * COEF_W,
    localparam int IDX_W   = $clog2(MSG_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_clr,
    input  logic                cnt_inc,
    input  logic                start,
    input  logic [MSG_BITS-1:0] msg,
    output logic                rd_en,
    output logic [IDX_W-1:0]    rd_addr,
    input  logic [ROW_W-1:0]    rd_data,
    output logic [ROW_W-1:0]    syn,
    output logic                done,
    output logic [PRNG_W-1:0]   attempt
);
    logic seed_load;
    logic acc_clear;
    logic scan;
    logic prng_bit;
    logic gate_d;

    sb_attempt_ctr #(.W(PRNG_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .value (attempt)
    );

    sb_ctrl #(.STEPS(MSG_BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .seed_load (seed_load),
        .acc_clear (acc_clear),
        .scan      (scan),
        .idx       (rd_addr),
        .done      (done)
    );

    sb_lfsr #(.W(PRNG_W), .TAP(PRNG_TAP), .SEED_OR(1)) u_prng (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seed_load),
        .seed    (attempt),
        .step    (scan),
        .out_bit (prng_bit)
    );

    // gate bit travels one cycle to meet the row read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_d <= 1'b0;
        end else begin
            gate_d <= scan && (msg[rd_addr] ^ prng_bit);
        end
    end

    sb_accum #(.N_COEF(N_COEF), .COEF_W(COEF_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (acc_clear),
        .add   (gate_d),
        .row   (rd_data),
        .syn   (syn)
    );

    assign rd_en = scan;

    // R4: a row is only added in the cycle after it was read
    a_r4_add_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        gate_d |-> $past(rd_en));
    // R7: done follows a read window that has just closed
    a_r7_done_after_reads: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_en && $past(rd_en, 2)));
endmodule

// File: tb/sim_syndrome_builder.sv
module sim_syndrome_builder;
    localparam int MB = 144;
    localparam int PW = 25;
    localparam int RW = 288;
    localparam int LAT = 147;

    typedef struct {
        logic [RW-1:0] syn;
        longint        due;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_clr = 1'b0, cnt_inc = 1'b0, start = 1'b0;
    logic [MB-1:0] msg = '0;
    logic          rd_en;
    logic [7:0]    rd_addr;
    logic [RW-1:0] rd_data = '0;
    logic [RW-1:0] syn;
    logic          done;
    logic [PW-1:0] attempt;

    int     errors = 0, checks = 0;
    longint cyc = 0;
    int     cnt_model = 0;
    item_t  q[$];
    int     rd_cnt = 0, rd_next = 0;
    bit     finished = 0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    syndrome_builder u0 (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
        .start(start), .msg(msg), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .syn(syn), .done(done), .attempt(attempt)
    );

    function automatic logic [RW-1:0] row_fn(int r);
        logic [RW-1:0] v;
        for (int k = 0; k < 18; k++) begin
            logic [31:0] h;
            h = (32'(r) * 32'd2654435761) ^ (32'(k) * 32'd40503) ^ 32'h5bd1e995;
            h = h ^ (h >> 13);
            h = h * 32'h27d4eb2d;
            h = h ^ (h >> 15);
            v[k*16 +: 16] = h[15:0];
        end
        return v;
    endfunction

    // matrix memory model: one cycle read latency (R5)
    always @(posedge clk) if (rd_en) rd_data <= row_fn(int'(rd_addr));

    function automatic logic [RW-1:0] expect_syn(logic [MB-1:0] m, int ctr);
        logic [PW-1:0] s;
        logic [RW-1:0] a;
        s = PW'(ctr) | PW'(1);
        a = '0;
        for (int j = 0; j < MB; j++) begin
            if (m[j] ^ s[0]) a = a ^ row_fn(j);
            s = {s[0] ^ s[3], s[PW-1:1]};
        end
        return a;
    endfunction

    function automatic logic [MB-1:0] cancel_msg(int ctr);
        logic [PW-1:0] s;
        logic [MB-1:0] m;
        s = PW'(ctr) | PW'(1);
        for (int j = 0; j < MB; j++) begin
            m[j] = s[0];
            s = {s[0] ^ s[3], s[PW-1:1]};
        end
        return m;
    endfunction

    task automatic check(bit ok, string what, logic [RW-1:0] act, logic [RW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // monitor: read window and scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rd_en) begin
                if (int'(rd_addr) != rd_next) begin
                    check(0, "R5 row address order", RW'(rd_addr), RW'(rd_next));
                end
                rd_next++;
                rd_cnt++;
            end
            if (done) begin
                if (q.size() == 0) begin
                    check(0, "R8 unexpected done", RW'(1), RW'(0));
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(syn == it.syn, {"R4 R6 syndrome ", it.tag}, syn, it.syn);
                    check(cyc == it.due, {"R7 done latency ", it.tag}, RW'(cyc), RW'(it.due));
                    check(rd_cnt == MB, {"R5 read count ", it.tag}, RW'(rd_cnt), RW'(MB));
                end
                rd_cnt = 0;
                rd_next = 0;
            end
        end
    end

    task automatic ctr_op(bit c, bit i);
        cnt_clr = c; cnt_inc = i;
        @(negedge clk);
        cnt_clr = 0; cnt_inc = 0;
        if (c) cnt_model = 0; else if (i) cnt_model++;
    endtask

    // driver: start a run, push its expectation, optionally poke mid-run
    task automatic run(logic [MB-1:0] m, string tag, bit poke_start, bit poke_inc);
        item_t it;
        msg = m;
        it.syn = expect_syn(m, cnt_model);
        it.tag = tag;
        it.due = cyc + LAT;
        q.push_back(it);
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (20) @(negedge clk);
        if (poke_start) begin
            start = 1; @(negedge clk); start = 0;
        end
        if (poke_inc) ctr_op(0, 1);
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : main
        logic [MB-1:0] pat;
        logic [RW-1:0] held;
        repeat (3) @(negedge clk);
        check(attempt == 0, "R1 reset counter", RW'(attempt), 0);
        check(done == 0, "R7 reset done", RW'(done), 0);
        check(rd_en == 0, "R5 reset read", RW'(rd_en), 0);
        check(syn == 0, "R6 reset syndrome", syn, 0);
        rst_n = 1;
        @(negedge clk);

        // R1 counter
        ctr_op(0, 1); ctr_op(0, 1); ctr_op(0, 1);
        check(attempt == 3, "R1 increment", RW'(attempt), 3);
        ctr_op(1, 1);
        check(attempt == 0, "R1 clear wins", RW'(attempt), 0);

        // R9: counter 0 and counter 1 give the same syndrome
        for (int b = 0; b < MB; b++) pat[b] = ((b * 7 + 3) % 5) < 2;
        run(pat, "ctr0", 0, 0);
        held = syn;
        ctr_op(0, 1);
        run(pat, "ctr1", 0, 0);
        check(syn == held, "R9 zero seed forced nonzero", syn, held);

        // R3 R4 distinct patterns and seeds
        run('0, "zeros", 0, 0);
        ctr_op(0, 1); ctr_op(0, 1);
        run('1, "ones", 0, 0);
        for (int b = 0; b < MB; b++) pat[b] = b[0] ^ b[3];
        ctr_op(0, 1);
        run(pat, "alt", 0, 0);

        // R4 no row gated -> zero syndrome
        run(cancel_msg(cnt_model), "cancel", 0, 0);
        check(syn == '0, "R4 nothing gated", syn, '0);

        // R6 hold between runs
        repeat (10) @(negedge clk);
        check(syn == '0, "R6 syndrome held", syn, '0);

        // R8 stray start, R2 counter change mid-run
        for (int b = 0; b < MB; b++) pat[b] = ((b * 13) % 11) > 5;
        run(pat, "stray start", 1, 0);
        run(pat, "inc mid-run", 0, 1);
        check(attempt == PW'(cnt_model), "R2 R1 counter after mid-run inc",
              RW'(attempt), RW'(cnt_model));
        ctr_op(0, 0);
        run(pat, "after inc", 0, 0);

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R8 scoreboard drained", RW'(q.size()), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule